// File: doc/BRIEF.md
# Accumulator Add-With-Carry Unit

This block performs the binary add-with-carry step of a small 8-bit processor datapath. Each cycle it sees the current accumulator byte, an already-resolved operand byte and the processor status byte. When the execute strobe is high, the next clock edge captures three things. The first is the truncated sum of accumulator, operand and incoming carry, which becomes the new accumulator. The second is a status byte in which the four arithmetic flags are recomputed. The third is that every other status bit is copied through unchanged.

Carry comes from a ninth sum bit. Zero and negative come from the stored 8-bit result. Signed overflow compares the sign bits of the two inputs with the sign bit of the result, so inputs of 0x7F and 0x80 are handled like any other value. Operand fetch, addressing, decimal arithmetic and subtraction belong to the surrounding datapath.

Status bit layout (fixed, decoded by neighbouring logic): bit 0 carry, bit 1 zero, bits 2 to 5 non-arithmetic bits, bit 6 overflow, bit 7 negative.

Top module: `adc_unit`

## Requirements
- R1: While rst_ni is low, acc_o and status_o are 0x00.
- R2: One clock edge after exec_i is sampled high, acc_o holds (acc_i + operand_i + status_i[0]) mod 256.
- R3: In the same update, status_o[0] (carry) is 1 exactly when the unsigned sum acc_i + operand_i + status_i[0] exceeds 255.
- R4: In the same update, status_o[1] (zero) is 1 exactly when the new acc_o is 0x00, including when a carry out occurred (0x01 + 0xFF gives zero and carry).
- R5: In the same update, status_o[7] (negative) equals bit 7 of the new acc_o.
- R6: In the same update, status_o[6] (overflow) is 1 exactly when acc_i and operand_i have the same bit 7 and the result's bit 7 differs from it; this holds for operands 0x7F and 0x80 (0x7F + 0x01 sets it, 0x80 + 0x7F + 1 clears it).
- R7: In the same update, status_o bits 2 to 5 equal status_i bits 2 to 5, and status_i bits 1, 6 and 7 have no effect on any output.
- R8: When exec_i is low at a clock edge, acc_o and status_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe; operand_i is valid while high |
| acc_i | input | 8 | Current accumulator value |
| operand_i | input | 8 | Resolved operand byte |
| status_i | input | 8 | Current status byte; bit 0 is the incoming carry |
| acc_o | output | 8 | Registered accumulator result |
| status_o | output | 8 | Registered status byte with updated flags |

## Verification
The block has one register stage, so the accumulator and all four flags are due at the first rising edge after exec_i is seen high. None of them is visible before that edge. The bench drives inputs on the falling edge and drops the strobe on the next falling edge. It reads the outputs there, half a period after the capturing edge. For the hold checks it changes the inputs with the strobe low, waits two further edges, and then confirms that the outputs still show the earlier result.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int STAT_W = 8;
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_V = 6;
  localparam int FLAG_N = 7;
  localparam logic [STAT_W-1:0] PASS_MASK = 8'h3C;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/adc_sum.sv
module adc_sum #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] carry;
  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prop;
    assign prop         = a_i[i] ^ b_i[i];
    assign sum_o[i]     = prop ^ carry[i];
    assign carry[i+1]   = (a_i[i] & b_i[i]) | (prop & carry[i]);
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/adc_flags.sv
module adc_flags
  import adc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic [W-1:0] res_i,
  input  logic         cout_i,
  output arith_flags_t flags_o
);
  logic res_msb;
  assign res_msb = res_i[W-1];

  always_comb begin
    flags_o.c = cout_i;
    flags_o.z = (res_i == '0);
    flags_o.n = res_msb;
    // signed overflow: like-signed inputs, result sign flipped
    flags_o.v = ~(a_msb_i ^ b_msb_i) & (a_msb_i ^ res_msb);
  end
endmodule

// File: rtl/adc_unit.sv
module adc_unit
  import adc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [W-1:0]      acc_i,
  input  logic [W-1:0]      operand_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [W-1:0]      acc_o,
  output logic [STAT_W-1:0] status_o
);
  logic [W-1:0]      sum;
  logic              cout;
  arith_flags_t      flags;
  logic [STAT_W-1:0] status_nxt;

  adc_sum #(.W(W)) u_sum (
    .a_i    (acc_i),
    .b_i    (operand_i),
    .cin_i  (status_i[FLAG_C]),
    .sum_o  (sum),
    .cout_o (cout)
  );

  adc_flags #(.W(W)) u_flags (
    .a_msb_i (acc_i[W-1]),
    .b_msb_i (operand_i[W-1]),
    .res_i   (sum),
    .cout_i  (cout),
    .flags_o (flags)
  );

  always_comb begin
    status_nxt         = status_i;
    status_nxt[FLAG_C] = flags.c;
    status_nxt[FLAG_Z] = flags.z;
    status_nxt[FLAG_V] = flags.v;
    status_nxt[FLAG_N] = flags.n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o    <= '0;
      status_o <= '0;
    end else if (exec_i) begin
      acc_o    <= sum;
      status_o <= status_nxt;
    end
  end
endmodule

// File: rtl/adc_unit_chk.sv
module adc_unit_chk
  import adc_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [W-1:0]      acc_i,
  input logic [W-1:0]      operand_i,
  input logic [STAT_W-1:0] status_i,
  input logic [W-1:0]      acc_o,
  input logic [STAT_W-1:0] status_o
);
  logic [W:0] ref_sum;
  assign ref_sum = {1'b0, acc_i} + {1'b0, operand_i} + {{W{1'b0}}, status_i[FLAG_C]};

  p_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> acc_o == $past(ref_sum[W-1:0]));

  p_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> status_o[FLAG_C] == $past(ref_sum[W]));

  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> status_o[FLAG_Z] == (acc_o == '0));

  p_neg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> status_o[FLAG_N] == acc_o[W-1]);

  p_ovf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> status_o[FLAG_V] ==
      (($past(acc_i[W-1]) == $past(operand_i[W-1])) && (acc_o[W-1] != $past(acc_i[W-1]))));

  p_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i |=> (status_o & PASS_MASK) == ($past(status_i) & PASS_MASK));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(acc_o) && $stable(status_o));
endmodule

bind adc_unit adc_unit_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .exec_i    (exec_i),
  .acc_i     (acc_i),
  .operand_i (operand_i),
  .status_i  (status_i),
  .acc_o     (acc_o),
  .status_o  (status_o)
);

// File: tb/adc_unit_tb.sv
module adc_unit_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       exec_i = 1'b0;
  logic [7:0] acc_i = '0;
  logic [7:0] operand_i = '0;
  logic [7:0] status_i = '0;
  logic [7:0] acc_o;
  logic [7:0] status_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .exec_i(exec_i), .acc_i(acc_i),
    .operand_i(operand_i), .status_i(status_i), .acc_o(acc_o), .status_o(status_o)
  );

  // {acc, operand, carry_in, exp_result, exp N V Z C}
  localparam logic [28:0] VEC [14] = '{
    {8'd36,  8'd36,  1'b0, 8'd72,  4'b0000},
    {8'd0,   8'd0,   1'b0, 8'd0,   4'b0010},
    {8'd72,  8'd200, 1'b0, 8'd16,  4'b0001},
    {8'd1,   8'd255, 1'b0, 8'd0,   4'b0011},
    {8'd32,  8'd200, 1'b0, 8'd232, 4'b1000},
    {8'd32,  8'd120, 1'b0, 8'd152, 4'b1100},
    {8'd144, 8'd208, 1'b0, 8'd96,  4'b0101},
    {8'h7F,  8'h01,  1'b0, 8'h80,  4'b1100},
    {8'h80,  8'h80,  1'b0, 8'h00,  4'b0111},
    {8'h7F,  8'h00,  1'b1, 8'h80,  4'b1100},
    {8'hFF,  8'hFF,  1'b1, 8'hFF,  4'b1001},
    {8'h80,  8'h7F,  1'b1, 8'h00,  4'b0011},
    {8'h7F,  8'h7F,  1'b0, 8'hFE,  4'b1100},
    {8'h80,  8'hFF,  1'b0, 8'h7F,  4'b0101}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] flags_byte(input logic n, input logic v, input logic z, input logic c);
    return {n, v, 4'b0000, z, c};
  endfunction

  // drive on falling edge, capture at next rising edge, sample at following falling edge
  task automatic run_op(input logic [7:0] a, input logic [7:0] m, input logic [7:0] st);
    @(negedge clk);
    acc_i = a; operand_i = m; status_i = st; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc in reset", acc_o, 8'h00);
    check("R1 status in reset", status_o, 8'h00);
    rst_ni = 1'b1;

    // table: R2 result, R3-R6 flags
    foreach (VEC[k]) begin
      logic [7:0] ea;
      logic [3:0] ef;
      ea = VEC[k][11:4];
      ef = VEC[k][3:0];
      run_op(VEC[k][28:21], VEC[k][20:13], {7'b0, VEC[k][12]});
      check("R2 table sum", acc_o, ea);
      check("R3 R4 R5 R6 table flags", status_o, flags_byte(ef[3], ef[2], ef[1], ef[0]));
    end

    // R7: pass-through bits copied, foreign bits ignored
    run_op(8'd36, 8'd36, 8'b1111_1110);
    check("R7 pass bits set, ignored bits", status_o, 8'b0011_1100);
    check("R7 sum unaffected", acc_o, 8'd72);
    run_op(8'd36, 8'd36, 8'b1100_0011);
    check("R7 pass bits clear", status_o, 8'b0000_0000);
    check("R2 carry in used", acc_o, 8'd73);

    // R8: hold with strobe low
    run_op(8'h7F, 8'h01, 8'h24);
    @(negedge clk);
    acc_i = 8'h01; operand_i = 8'hFF; status_i = 8'hFF;
    repeat (2) @(negedge clk);
    check("R8 acc hold", acc_o, 8'h80);
    check("R8 status hold", status_o, 8'hE4);

    // R2-R7 random against reference model
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a, m, st, r, es;
      int s, sa, sm, ss;
      a = 8'($urandom); m = 8'($urandom); st = 8'($urandom);
      s = int'(a) + int'(m) + int'(st[0]);
      r = 8'(s);
      sa = (a > 127) ? int'(a) - 256 : int'(a);
      sm = (m > 127) ? int'(m) - 256 : int'(m);
      ss = sa + sm + int'(st[0]);
      es = (st & 8'h3C) | flags_byte(r[7], (ss > 127) || (ss < -128), r == 8'h00, s > 255);
      run_op(a, m, st);
      check("R2 random sum", acc_o, r);
      check("R3 R4 R5 R6 R7 random status", status_o, es);
    end

    // R1: reset mid-run clears registers
    run_op(8'h90, 8'hD0, 8'h00);
    #2 rst_ni = 1'b0;
    #1;
    check("R1 acc async reset", acc_o, 8'h00);
    check("R1 status async reset", status_o, 8'h00);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule